// File: doc/BRIEF.md
# Privilege-Level Way Mask for an Instruction Cache

This block decides which ways of a set-associative L1 instruction cache may be searched on each fetch. Every line carries a 2-bit privilege tag. The tag is written when the line is filled, and it records the execution level in force at that time (level 0 is kernel, level 3 is user). For each set, the block also keeps a ready-made way mask with one bit per way. A mask bit is 1 when the line in that way belongs to the current execution level. On a fetch, the indexed set's mask, qualified by the line valid bits, is driven straight out as the per-way enables for both the tag compare and the data read. No level comparison sits on the lookup path.

The comparison happens instead when a line is installed, as part of miss handling. When the execution level changes, the masks are brought up to date in one of two ways:
- A swap between kernel and user flips every mask bit in a single cycle.
- A change to or from level 1 or 2 starts a recompute sweep that visits one set per cycle. Fetches are held off through a busy output until the sweep finishes.

The tag and data arrays, the fill request logic and the TLB sit outside this block.

Top module: `imask_top`

## Requirements
- R1: After reset, `busy` is 0 and `wayEn` is 0 for every set, because all lines start invalid.
- R2: A fill of way w in set s takes effect at the next clock edge. From then on, a fetch of set s that finds the level unchanged has bit w of `wayEn` set.
- R3: `wayEn` depends only on inputs and state, in the same cycle. It equals the valid bits ANDed with the mask of set `fetchSet` when `fetchValid` is 1 and `busy` is 0, and it is 0 otherwise. A way that has never been filled is never enabled.
- R4: Take any line whose tag is 0 or 3. On a fetch, its `wayEn` bit is 1 exactly when its tag equals the current level. A user fetch therefore never enables a way that holds kernel code, and the reverse holds too.
- R5: Suppose `levelChg` moves the level between 0 and 3 while `busy` is 0. Then every mask bit of every set is inverted at the next edge, and `busy` stays 0.
- R6: Suppose `levelChg` changes the level and either the old or the new level is 1 or 2. Then `busy` is 1 for exactly NumSets cycles, starting at the next edge, and `wayEn` is 0 during that time. Afterwards, every mask bit equals (line tag == new level).
- R7: A `levelChg` strobe whose `curLevel` equals the current level has no effect.
- R8: `curLevel` is sampled only when `levelChg` is 1. Without the strobe, changes on `curLevel` alter neither `wayEn` nor the tag written by a fill.
- R9: When a fill and a level change arrive in the same cycle, the level change is applied first. The new line is tagged with the new level, and its way is enabled under that level.
- R10: A level change that arrives while `busy` is 1 restarts the sweep from set 0. `busy` then stays 1 for NumSets cycles, counted from that strobe.
- R11: Refilling a way replaces its level tag and sets its mask bit for the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curLevel | input | 2 | Execution level; 0 kernel, 3 user |
| levelChg | input | 1 | Strobe: adopt `curLevel` as the execution level |
| fillValid | input | 1 | A line is installed this cycle |
| fillSet | input | $clog2(NumSets) | Set of the installed line |
| fillWay | input | $clog2(NumWays) | Way of the installed line |
| fetchValid | input | 1 | A fetch lookup this cycle |
| fetchSet | input | $clog2(NumSets) | Set indexed by the fetch |
| busy | output | 1 | Recompute sweep in progress; fetches must stall |
| wayEn | output | NumWays | Per-way enable for tag compare and data read |

## Verification
The hardest state to reach combines lines tagged with levels 1 or 2 and lines tagged 0 and 3 in the same set, followed by level changes of both kinds. This combination is what separates the single-cycle inversion path from the sweep path. It also exposes the points where inversion leaves mid-level lines over-enabled. The directed phase builds one such set by hand. It then steps through a kernel-user swap, a same-cycle fill and change, a sweep, and a sweep restarted mid-flight. A seeded random phase then mixes fills, fetches and strobes, with mid-levels included, and compares every cycle against a bench model of the mask rules.

// File: rtl/imask_pkg.sv
package imask_pkg;
  localparam int LvlW = 2;
  localparam logic [LvlW-1:0] LvlKernel = 2'd0;
  localparam logic [LvlW-1:0] LvlUser   = 2'd3;

  // strobes from the control to the datapath
  typedef struct packed {
    logic            invertAll;
    logic            sweepEn;
    logic [LvlW-1:0] lvl;       // level in force for this edge
  } ctrl_t;
endpackage

// File: rtl/imask_ctrl.sv
module imask_ctrl
  import imask_pkg::*;
#(
  parameter int NumSets = 64,
  localparam int SetW = $clog2(NumSets)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LvlW-1:0] curLevel,
  input  logic            levelChg,
  output ctrl_t           ctrl,
  output logic [SetW-1:0] sweepSet,
  output logic            busy
);
  localparam logic [SetW-1:0] LastSet = SetW'(NumSets - 1);

  logic [LvlW-1:0] curLvlQ;
  logic [SetW-1:0] sweepIdx;
  logic            busyQ;
  logic            realChg;
  logic            midLvl;
  logic            startSweep;

  // levels 1 and 2 are the ones whose encodings have differing bits
  assign realChg    = levelChg && (curLevel != curLvlQ);
  assign midLvl     = (curLevel[0] ^ curLevel[1]) || (curLvlQ[0] ^ curLvlQ[1]);
  assign startSweep = realChg && (busyQ || midLvl);

  always_comb begin
    ctrl.invertAll = realChg && !busyQ && !midLvl;
    ctrl.sweepEn   = busyQ;
    ctrl.lvl       = levelChg ? curLevel : curLvlQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLvlQ  <= LvlKernel;
      sweepIdx <= '0;
      busyQ    <= 1'b0;
    end else begin
      if (realChg) curLvlQ <= curLevel;
      if (startSweep) begin
        busyQ    <= 1'b1;
        sweepIdx <= '0;
      end else if (busyQ) begin
        if (sweepIdx == LastSet) busyQ <= 1'b0;
        sweepIdx <= sweepIdx + 1'b1;
      end
    end
  end

  assign sweepSet = sweepIdx;
  assign busy     = busyQ;

  // R6
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(sweepIdx) == LastSet));

  // R5
  swap_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelChg && !busyQ && (curLevel != curLvlQ)
     && (curLevel == LvlKernel || curLevel == LvlUser)
     && (curLvlQ == LvlKernel || curLvlQ == LvlUser)) |=> !busyQ);

  // R10
  sweep_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && levelChg && (curLevel != curLvlQ)) |=> (busyQ && sweepIdx == '0));
endmodule

// File: rtl/imask_dpath.sv
module imask_dpath
  import imask_pkg::*;
#(
  parameter int NumSets = 64,
  parameter int NumWays = 8,
  localparam int SetW = $clog2(NumSets),
  localparam int WayW = $clog2(NumWays)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [SetW-1:0]    sweepSet,
  input  logic               busy,
  input  logic               fillValid,
  input  logic [SetW-1:0]    fillSet,
  input  logic [WayW-1:0]    fillWay,
  input  logic               fetchValid,
  input  logic [SetW-1:0]    fetchSet,
  output logic [NumWays-1:0] wayEn
);
  logic [LvlW-1:0]    lvlTag [NumSets][NumWays];
  logic [NumWays-1:0] validQ [NumSets];
  logic [NumWays-1:0] maskQ  [NumSets];
  logic [NumWays-1:0] sweepRow;

  // level compare for the swept set, one comparator per way
  for (genvar w = 0; w < NumWays; w++) begin : g_cmp
    assign sweepRow[w] = (lvlTag[sweepSet][w] == ctrl.lvl);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NumSets; s++) begin
        validQ[s] <= '0;
        maskQ[s]  <= '0;
        for (int w = 0; w < NumWays; w++) lvlTag[s][w] <= LvlKernel;
      end
    end else begin
      if (ctrl.invertAll)
        for (int s = 0; s < NumSets; s++) maskQ[s] <= ~maskQ[s];
      if (ctrl.sweepEn) maskQ[sweepSet] <= sweepRow;
      // install last: a fill sees the level change of its own cycle
      if (fillValid) begin
        lvlTag[fillSet][fillWay] <= ctrl.lvl;
        validQ[fillSet][fillWay] <= 1'b1;
        maskQ[fillSet][fillWay]  <= 1'b1;  // new tag equals the level in force
      end
    end
  end

  assign wayEn = (fetchValid && !busy) ? (maskQ[fetchSet] & validQ[fetchSet]) : '0;

  // R2
  fill_enables_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> (maskQ[$past(fillSet)][$past(fillWay)] && validQ[$past(fillSet)][$past(fillWay)]));

  // R5
  invert_set0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.invertAll && !(fillValid && fillSet == '0)) |=> (maskQ[0] == ~$past(maskQ[0])));

  // R6
  sweep_set0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.sweepEn && sweepSet == '0 && !(fillValid && fillSet == '0))
      |=> (maskQ[0][0] == ($past(lvlTag[0][0]) == $past(ctrl.lvl))));
endmodule

// File: rtl/imask_top.sv
module imask_top
  import imask_pkg::*;
#(
  parameter int NumSets = 64,
  parameter int NumWays = 8,
  localparam int SetW = $clog2(NumSets),
  localparam int WayW = $clog2(NumWays)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         curLevel,
  input  logic               levelChg,
  input  logic               fillValid,
  input  logic [SetW-1:0]    fillSet,
  input  logic [WayW-1:0]    fillWay,
  input  logic               fetchValid,
  input  logic [SetW-1:0]    fetchSet,
  output logic               busy,
  output logic [NumWays-1:0] wayEn
);
  ctrl_t           ctrl;
  logic [SetW-1:0] sweepSet;

  imask_ctrl #(.NumSets(NumSets)) u_ctrl (
    .clk(clk), .rstN(rstN), .curLevel(curLevel), .levelChg(levelChg),
    .ctrl(ctrl), .sweepSet(sweepSet), .busy(busy)
  );

  imask_dpath #(.NumSets(NumSets), .NumWays(NumWays)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sweepSet(sweepSet), .busy(busy),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .fetchValid(fetchValid), .fetchSet(fetchSet), .wayEn(wayEn)
  );
endmodule

// File: tb/imask_top_tb.sv
`timescale 1ns/1ps
module imask_top_tb;
  localparam int NS = 64;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [1:0] curLevel;
  logic levelChg, fillValid, fetchValid;
  logic [5:0] fillSet, fetchSet;
  logic [2:0] fillWay;
  logic busy;
  logic [NW-1:0] wayEn;

  imask_top #(.NumSets(NS), .NumWays(NW)) u_dut (
    .clk(clk), .rstN(rstN), .curLevel(curLevel), .levelChg(levelChg),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .fetchValid(fetchValid), .fetchSet(fetchSet), .busy(busy), .wayEn(wayEn)
  );

  // bench model of the mask rules
  logic [1:0]    mTag [NS][NW];
  logic [NW-1:0] mVal [NS];
  logic [NW-1:0] mMask [NS];
  logic [1:0]    mLvl;
  int            mCnt;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit chg, input logic [1:0] lvl, input bit fv, input int fs,
                     input int fw, input bit ftv, input int fts, input string tag);
    logic [1:0] eff;
    bit realChg, mid;
    logic [NW-1:0] expEn;
    levelChg = chg; curLevel = lvl; fillValid = fv; fillSet = 6'(fs); fillWay = 3'(fw);
    fetchValid = ftv; fetchSet = 6'(fts);
    #1;
    expEn = (ftv && mCnt == 0) ? (mVal[fts] & mMask[fts]) : '0;
    check(tag, 64'(busy), 64'(mCnt != 0));
    check(tag, 64'(wayEn), 64'(expEn));
    eff = chg ? lvl : mLvl;
    realChg = chg && (lvl != mLvl);
    mid = (lvl == 2'd1) || (lvl == 2'd2) || (mLvl == 2'd1) || (mLvl == 2'd2);
    if (mCnt > 0)
      for (int w = 0; w < NW; w++) mMask[NS - mCnt][w] = (mTag[NS - mCnt][w] == eff);
    if (realChg && mCnt == 0 && !mid)
      for (int s = 0; s < NS; s++) mMask[s] = ~mMask[s];
    if (realChg && (mCnt > 0 || mid)) mCnt = NS;
    else if (mCnt > 0) mCnt--;
    if (fv) begin
      mTag[fs][fw] = eff; mVal[fs][fw] = 1'b1; mMask[fs][fw] = 1'b1;
    end
    if (realChg) mLvl = lvl;
    @(negedge clk);
  endtask

  task automatic probe(input int s, input logic [NW-1:0] exp, input string tag);
    levelChg = 0; fillValid = 0; fetchValid = 1; fetchSet = 6'(s);
    #1;
    check(tag, 64'(wayEn), 64'(exp));
    cyc(0, curLevel, 0, 0, 0, 1, s, tag);
  endtask

  task automatic countBusy(output int n, input logic [1:0] lvl, input string tag);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      cyc(0, lvl, 0, 0, 0, 1, 5, tag);  // fetch must stay blocked
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [1:0] lv;
    rstN = 0; levelChg = 0; curLevel = 0; fillValid = 0; fetchValid = 0;
    fillSet = 0; fillWay = 0; fetchSet = 0;
    for (int s = 0; s < NS; s++) begin
      mVal[s] = '0; mMask[s] = '0;
      for (int w = 0; w < NW; w++) mTag[s][w] = 2'd0;
    end
    mLvl = 0; mCnt = 0;
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    check("R1", 64'(busy), 64'd0);
    probe(5, 8'h00, "R1");
    probe(63, 8'h00, "R1");
    // R2 fill at kernel level
    cyc(0, 0, 1, 5, 2, 0, 0, "R2");
    probe(5, 8'h04, "R2");
    // R3 no fetch, and an untouched set
    cyc(0, 0, 0, 0, 0, 0, 5, "R3");
    probe(9, 8'h00, "R3");
    // R9 + R5: swap to user with a fill in the same cycle
    cyc(1, 3, 1, 5, 4, 0, 0, "R9");
    probe(5, 8'h10, "R5");
    // R8: curLevel moves without strobe; fill still tagged user
    cyc(0, 0, 1, 5, 6, 0, 0, "R8");
    probe(5, 8'h50, "R8");
    // R7: strobe with unchanged level
    cyc(1, 3, 0, 0, 0, 0, 0, "R7");
    probe(5, 8'h50, "R7");
    // R6: move to level 1 starts a sweep
    cyc(1, 1, 0, 0, 0, 0, 0, "R6");
    countBusy(n, 1, "R6");
    check("R6", 64'(n), 64'(NS));
    probe(5, 8'h00, "R6");
    cyc(0, 1, 1, 5, 1, 0, 0, "R2");
    probe(5, 8'h02, "R2");
    cyc(1, 3, 0, 0, 0, 0, 0, "R6");
    countBusy(n, 3, "R6");
    check("R6", 64'(n), 64'(NS));
    probe(5, 8'h50, "R6");
    // R4: swap back to kernel; only lines tagged 0 or 3 are exact
    cyc(1, 0, 0, 0, 0, 0, 0, "R4");
    levelChg = 0; fillValid = 0; fetchValid = 1; fetchSet = 6'd5;
    #1;
    check("R4", 64'(wayEn & 8'h54), 64'h04);
    cyc(0, 0, 0, 0, 0, 1, 5, "R4");
    // R10: restart in mid-sweep
    cyc(1, 2, 0, 0, 0, 0, 0, "R10");
    repeat (10) cyc(0, 2, 0, 0, 0, 1, 5, "R10");
    cyc(1, 1, 0, 0, 0, 0, 0, "R10");
    countBusy(n, 1, "R10");
    check("R10", 64'(n), 64'(NS));
    probe(5, 8'h02, "R10");
    // R11: refill way 4 at level 1
    cyc(0, 1, 1, 5, 4, 0, 0, "R11");
    probe(5, 8'h12, "R11");

    // seeded random mix checked against the model
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 10;
      lv = (r < 4) ? 2'd0 : (r < 8) ? 2'd3 : (r == 8) ? 2'd1 : 2'd2;
      cyc(($urandom % 25) == 0, lv, ($urandom % 3) == 0, $urandom % NS, $urandom % NW,
          ($urandom % 2) == 0, $urandom % NS, "R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule